// File: doc/BRIEF.md
# Size-Aware Integer Register File

This block holds the integer register state of a 32-bit core: one bank of general data registers and one bank of address registers, each 32 bits wide. Every access names an operand size of byte, word or longword. Writes into a data register merge only the low lane the size covers and keep the higher bits. Writes into an address register always replace the whole register, and a word source is sign-extended first. Byte operands on an address register, and the unused size code, are refused: they are flagged and change nothing.

Two combinational read ports deliver the selected register at the requested size. Data-register lanes are zero-padded. A word read of an address register is sign-extended from bit 15. One synchronous write port commits on the rising clock edge. A same-cycle read of the register being written sees the old contents.

A small condition-code register sits beside the banks. It is accessed as a 16-bit word. Its upper byte always reads as zero, and its reserved low bits, given by a parameter mask, also read as zero whatever is written.

Top module: `sized_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every data register, every address register and the condition-code register are cleared to zero.
- R2: A longword write (size code 2'b10) to a data register replaces all 32 bits with `wr_data`.
- R3: A byte write (size code 2'b00) to a data register changes only bits 7:0. A word write (size code 2'b01) changes only bits 15:0. The upper bits keep their previous values.
- R4: A data-register read returns bits 7:0 zero-extended for byte size, bits 15:0 zero-extended for word size, and all 32 bits for longword size.
- R5: Byte size on an address register, and size code 2'b11 on any register, is illegal. An illegal write raises `wr_illegal` while `wr_en` is high and modifies no register. An illegal read raises that port's illegal flag and returns zero.
- R6: A word write to an address register stores `wr_data[15:0]` sign-extended from bit 15 to 32 bits. A longword write stores all 32 bits. In both cases the whole register is replaced.
- R7: An address-register read at word size returns bits 15:0 sign-extended from bit 15. At longword size it returns all 32 bits.
- R8: `ccr_rdata[15:8]` always reads zero, and bits of the low byte outside `CCR_MASK` read zero. A condition-code write stores `ccr_wdata[7:0] & CCR_MASK` at the rising edge.
- R9: Reads are combinational from stored state. A write commits at the rising edge when `wr_en` is high. A read in the same cycle as a write to the same register returns the old value. With `wr_en` low, no register changes.
- R10: Index bit 3 (the top index bit) set to 1 selects address register `idx[2:0]`. Set to 0, it selects data register `idx[2:0]`. The two banks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 4 | Write register index, top bit selects the address bank |
| wr_size | input | 2 | Write operand size: 00 byte, 01 word, 10 longword, 11 illegal |
| wr_data | input | 32 | Write source operand |
| wr_illegal | output | 1 | The current write request is refused |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 operand size |
| rd0_data | output | 32 | Read port 0 operand, extended to 32 bits |
| rd0_illegal | output | 1 | Read port 0 request is refused |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 operand size |
| rd1_data | output | 32 | Read port 1 operand, extended to 32 bits |
| rd1_illegal | output | 1 | Read port 1 request is refused |
| ccr_we | input | 1 | Condition-code write enable |
| ccr_wdata | input | 16 | Condition-code write word |
| ccr_rdata | output | 16 | Condition-code read word |

## Verification
The bench builds the block with its default eight registers per bank and a condition-code mask of 8'h1F. With these values both banks fit a 4-bit index, so random traffic hits every register, both bank halves and all four size codes, including the refused combinations. The narrow mask leaves three reserved low bits next to the upper byte, so all-ones writes show that both kinds of discarded bits read back as zero. Random write and read indices often collide, which exercises the old-value-on-same-cycle rule along with the directed sign boundaries 16'h7FFF and 16'h8000.

// File: rtl/rf_pkg.sv
// Shared definitions for the size-aware register file.
// Assumes a 32-bit register width; byte and word lanes are fixed at 8 and 16.
package rf_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } opsize_e;

    // Legal size/bank combination: byte never on the address bank, code 11 never.
    function automatic logic size_legal(opsize_e sz, logic is_addr);
        return (sz == SZ_LONG) || (sz == SZ_WORD) || ((sz == SZ_BYTE) && !is_addr);
    endfunction
endpackage

// File: rtl/rf_wr_merge.sv
// Write-lane merge: builds the next value of the target register from its old
// contents, the source operand, the operand size and the bank.
// Assumes the caller only commits when legal is high.
module rf_wr_merge
    import rf_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [1:0]      size,
    input  logic            is_addr,
    output logic [XLEN-1:0] merged,
    output logic            legal
);
    opsize_e sz;
    assign sz = opsize_e'(size);

    // Merge the covered lane, or replace and sign-extend for the address bank.
    always_comb begin
        legal  = size_legal(sz, is_addr);
        merged = old_val;
        case (sz)
            SZ_BYTE: merged = {old_val[XLEN-1:8], src_val[7:0]};
            SZ_WORD: merged = is_addr ? {{(XLEN-16){src_val[15]}}, src_val[15:0]}
                                      : {old_val[XLEN-1:16], src_val[15:0]};
            SZ_LONG: merged = src_val;
            default: merged = old_val;
        endcase
        if (!legal) merged = old_val;
    end
endmodule

// File: rtl/rf_rd_extract.sv
// Read-lane extraction: returns the requested lane of a stored register,
// zero-extended for the data bank and sign-extended for address word reads.
// Assumes purely combinational use; refused requests return zero.
module rf_rd_extract
    import rf_pkg::*;
(
    input  logic [XLEN-1:0] stored,
    input  logic [1:0]      size,
    input  logic            is_addr,
    output logic [XLEN-1:0] operand,
    output logic            legal
);
    opsize_e sz;
    assign sz = opsize_e'(size);

    // Select and extend the lane named by the size code.
    always_comb begin
        legal   = size_legal(sz, is_addr);
        operand = '0;
        case (sz)
            SZ_BYTE: operand = {{(XLEN-8){1'b0}}, stored[7:0]};
            SZ_WORD: operand = is_addr ? {{(XLEN-16){stored[15]}}, stored[15:0]}
                                       : {{(XLEN-16){1'b0}}, stored[15:0]};
            SZ_LONG: operand = stored;
            default: operand = '0;
        endcase
        if (!legal) operand = '0;
    end
endmodule

// File: rtl/rf_ccr.sv
// Condition-code register: word-wide access, only the low byte is stored and
// only the bits in CCR_MASK survive. Assumes synchronous active-low reset.
module rf_ccr #(
    parameter logic [7:0] CCR_MASK = 8'h1F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    logic [7:0] ccr_q;

    // Store the implemented low-byte bits; upper byte is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)  ccr_q <= '0;
        else if (we) ccr_q <= wdata[7:0] & CCR_MASK;
    end

    // Upper byte and reserved bits read as zero.
    assign rdata = {8'h00, ccr_q & CCR_MASK};
endmodule

// File: rtl/sized_regfile.sv
// Size-aware register file: NREG data registers and NREG address registers,
// one write port with lane merging, two combinational read ports with lane
// extension, and a condition-code register. The top index bit selects the
// address bank. No read-during-write bypass. Synchronous active-low reset.
module sized_regfile
    import rf_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter logic [7:0] CCR_MASK = 8'h1F,
    localparam int        SEL_W    = $clog2(NREG),
    localparam int        IDX_W    = SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_illegal,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_size,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_illegal,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_size,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_illegal,
    input  logic             ccr_we,
    input  logic [15:0]      ccr_wdata,
    output logic [15:0]      ccr_rdata
);
    localparam int NTOT   = 2 * NREG;
    localparam int NPORTS = 2;

    logic [XLEN-1:0]      regs_q [NTOT];
    logic [NTOT*XLEN-1:0] regs_flat;
    logic [XLEN-1:0]      wr_old;
    logic [XLEN-1:0]      wr_next;
    logic                 wr_legal;
    logic                 wr_commit;

    logic [IDX_W-1:0] rp_idx     [NPORTS];
    logic [1:0]       rp_size    [NPORTS];
    logic [XLEN-1:0]  rp_data    [NPORTS];
    logic             rp_legal   [NPORTS];

    // Write path: merge the source into the current contents of the target.
    assign wr_old = regs_q[wr_idx];

    rf_wr_merge u_merge (
        .old_val (wr_old),
        .src_val (wr_data),
        .size    (wr_size),
        .is_addr (wr_idx[IDX_W-1]),
        .merged  (wr_next),
        .legal   (wr_legal)
    );

    assign wr_commit  = wr_en && wr_legal;
    assign wr_illegal = wr_en && !wr_legal;

    // One storage element per register, both banks.
    for (genvar i = 0; i < NTOT; i++) begin : g_reg
        // Clear on reset, load the merged value when this register is targeted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_commit && (wr_idx == IDX_W'(i)))
                regs_q[i] <= wr_next;
        end
        assign regs_flat[i*XLEN +: XLEN] = regs_q[i];
    end

    // Gather the read ports so they share one generated extractor structure.
    assign rp_idx[0]  = rd0_idx;
    assign rp_size[0] = rd0_size;
    assign rp_idx[1]  = rd1_idx;
    assign rp_size[1] = rd1_size;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        rf_rd_extract u_ext (
            .stored  (regs_q[rp_idx[p]]),
            .size    (rp_size[p]),
            .is_addr (rp_idx[p][IDX_W-1]),
            .operand (rp_data[p]),
            .legal   (rp_legal[p])
        );
    end

    assign rd0_data    = rp_data[0];
    assign rd0_illegal = !rp_legal[0];
    assign rd1_data    = rp_data[1];
    assign rd1_illegal = !rp_legal[1];

    rf_ccr #(.CCR_MASK(CCR_MASK)) u_ccr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ccr_we),
        .wdata (ccr_wdata),
        .rdata (ccr_rdata)
    );
endmodule

// File: rtl/sized_regfile_chk.sv
// Property checker for sized_regfile, attached by bind. Observes the ports and
// the flattened register state; drives nothing back into the design.
module sized_regfile_chk
    import rf_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter logic [7:0] CCR_MASK = 8'h1F,
    localparam int        SEL_W    = $clog2(NREG),
    localparam int        IDX_W    = SEL_W + 1,
    localparam int        NTOT     = 2 * NREG
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [1:0]           wr_size,
    input logic [XLEN-1:0]      wr_data,
    input logic                 wr_illegal,
    input logic [IDX_W-1:0]     rd0_idx,
    input logic [1:0]           rd0_size,
    input logic [XLEN-1:0]      rd0_data,
    input logic                 rd0_illegal,
    input logic [15:0]          ccr_rdata,
    input logic [NTOT*XLEN-1:0] regs_flat
);
    logic [IDX_W-1:0] idx_d;
    logic [XLEN-1:0]  tgt_now;
    logic [XLEN-1:0]  tgt_after;

    // Remember last cycle's write index to look at the same register afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_d <= '0;
        else        idx_d <= wr_idx;
    end

    assign tgt_now   = regs_flat[int'(wr_idx)*XLEN +: XLEN];
    assign tgt_after = regs_flat[int'(idx_d)*XLEN +: XLEN];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0) && (ccr_rdata == 16'h0000)); // R1

    AST_DATA_LONG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_idx[IDX_W-1] && wr_size == 2'b10)
        |=> tgt_after == $past(wr_data)); // R2

    AST_DATA_BYTE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_idx[IDX_W-1] && wr_size == 2'b00)
        |=> tgt_after == {$past(tgt_now[XLEN-1:8]), $past(wr_data[7:0])}); // R3

    AST_DATA_WORD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_idx[IDX_W-1] && wr_size == 2'b01)
        |=> tgt_after == {$past(tgt_now[XLEN-1:16]), $past(wr_data[15:0])}); // R3

    AST_DATA_RD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0_idx[IDX_W-1] && rd0_size == 2'b01) |-> rd0_data[XLEN-1:16] == '0); // R4

    AST_ADDR_BYTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1] && wr_size == 2'b00) |-> wr_illegal); // R5

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_illegal) |=> $stable(regs_flat)); // R5

    AST_ILLEGAL_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_illegal |-> rd0_data == '0); // R5

    AST_ADDR_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1] && wr_size == 2'b01)
        |=> tgt_after == {{(XLEN-16){$past(wr_data[15])}}, $past(wr_data[15:0])}); // R6

    AST_ADDR_RD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_idx[IDX_W-1] && rd0_size == 2'b01)
        |-> rd0_data[XLEN-1:16] == {(XLEN-16){rd0_data[15]}}); // R7

    AST_CCR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_rdata[15:8] == 8'h00) && ((ccr_rdata[7:0] & ~CCR_MASK) == 8'h00)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat)); // R9
endmodule

bind sized_regfile sized_regfile_chk #(.NREG(NREG), .CCR_MASK(CCR_MASK)) u_chk (.*);

// File: tb/sim_sized_regfile.sv
`timescale 1ns/1ps
// Bench for sized_regfile: directed corner cases then seeded random traffic,
// compared against a bench-side model built from the requirements.
module sim_sized_regfile;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_illegal;
    logic [3:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = '0;
    logic [31:0] rd0_data;
    logic        rd0_illegal;
    logic [3:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = '0;
    logic [31:0] rd1_data;
    logic        rd1_illegal;
    logic        ccr_we = 1'b0;
    logic [15:0] ccr_wdata = '0;
    logic [15:0] ccr_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] mdl [16];
    logic [7:0]  mccr;

    always #5 clk = ~clk;

    sized_regfile #(.NREG(NREG), .CCR_MASK(8'h1F)) u0 (.*);

    // Expected read: {illegal, operand}.
    function automatic logic [32:0] f_read(logic [31:0] v, logic [1:0] sz, logic is_a);
        case (sz)
            2'b00: return is_a ? {1'b1, 32'h0} : {1'b0, 24'h0, v[7:0]};
            2'b01: return is_a ? {1'b0, {16{v[15]}}, v[15:0]} : {1'b0, 16'h0, v[15:0]};
            2'b10: return {1'b0, v};
            default: return {1'b1, 32'h0};
        endcase
    endfunction

    // Expected write: {illegal, next value}.
    function automatic logic [32:0] f_write(logic [31:0] o, logic [31:0] n, logic [1:0] sz, logic is_a);
        case (sz)
            2'b00: return is_a ? {1'b1, o} : {1'b0, o[31:8], n[7:0]};
            2'b01: return is_a ? {1'b0, {16{n[15]}}, n[15:0]} : {1'b0, o[31:16], n[15:0]};
            2'b10: return {1'b0, n};
            default: return {1'b1, o};
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check reads before the rising edge,
    // then advance the model past the edge.
    task automatic step(input logic wen, input logic [3:0] widx, input logic [1:0] wsz,
                        input logic [31:0] wd, input logic [3:0] r0, input logic [1:0] s0,
                        input logic [3:0] r1, input logic [1:0] s1,
                        input logic cwe, input logic [15:0] cwd, input string req);
        logic [32:0] e0, e1, ew;
        @(negedge clk);
        wr_en = wen; wr_idx = widx; wr_size = wsz; wr_data = wd;
        rd0_idx = r0; rd0_size = s0; rd1_idx = r1; rd1_size = s1;
        ccr_we = cwe; ccr_wdata = cwd;
        #1;
        e0 = f_read(mdl[r0], s0, r0[3]);
        e1 = f_read(mdl[r1], s1, r1[3]);
        ew = f_write(mdl[widx], wd, wsz, widx[3]);
        chk(req, "rd0_data", rd0_data, e0[31:0]);
        chk(req, "rd0_illegal", {31'h0, rd0_illegal}, {31'h0, e0[32]});
        chk(req, "rd1_data", rd1_data, e1[31:0]);
        chk(req, "rd1_illegal", {31'h0, rd1_illegal}, {31'h0, e1[32]});
        chk(req, "wr_illegal", {31'h0, wr_illegal}, {31'h0, wen & ew[32]});
        chk(req, "ccr_rdata", {16'h0, ccr_rdata}, {24'h0, mccr});
        @(posedge clk);
        if (wen && !ew[32]) mdl[widx] = ew[31:0];
        if (cwe) mccr = cwd[7:0] & 8'h1F;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; ccr_we = 1'b0;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        mccr = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_all_zero(string req);
        for (int i = 0; i < 16; i++)
            step(1'b0, 4'd0, 2'b10, 32'h0, 4'(i), 2'b10, 4'(i), 2'b01, 1'b0, 16'h0, req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2026));
        for (int i = 0; i < 16; i++) mdl[i] = 'x;
        mccr = 'x;
        do_reset();
        check_all_zero("R1");

        // R2: longword into data register 2
        step(1'b1, 4'd2, 2'b10, 32'hA5A5_1234, 4'd2, 2'b10, 4'd0, 2'b10, 1'b0, 16'h0, "R2");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd2, 2'b10, 4'd2, 2'b10, 1'b0, 16'h0, "R2");
        // R3: byte then word merge, upper bits kept
        step(1'b1, 4'd2, 2'b00, 32'hFFFF_FF77, 4'd2, 2'b10, 4'd2, 2'b10, 1'b0, 16'h0, "R3");
        step(1'b1, 4'd2, 2'b01, 32'h0000_BEEF, 4'd2, 2'b10, 4'd2, 2'b10, 1'b0, 16'h0, "R3");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd2, 2'b10, 4'd2, 2'b10, 1'b0, 16'h0, "R3");
        // R4: zero-extended narrow reads of a value with bit 15 and bit 7 set
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd2, 2'b00, 4'd2, 2'b01, 1'b0, 16'h0, "R4");
        // R5: byte write to address register 1 refused, code 11 refused
        step(1'b1, 4'd9, 2'b10, 32'h1234_5678, 4'd9, 2'b10, 4'd3, 2'b10, 1'b0, 16'h0, "R5");
        step(1'b1, 4'd9, 2'b00, 32'h0000_00FF, 4'd9, 2'b10, 4'd9, 2'b00, 1'b0, 16'h0, "R5");
        step(1'b1, 4'd3, 2'b11, 32'hFFFF_FFFF, 4'd9, 2'b10, 4'd3, 2'b11, 1'b0, 16'h0, "R5");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd9, 2'b10, 4'd3, 2'b10, 1'b0, 16'h0, "R5");
        // R6: word writes to address register sign-extend at both boundaries
        step(1'b1, 4'd9, 2'b01, 32'h1234_8000, 4'd9, 2'b10, 4'd9, 2'b10, 1'b0, 16'h0, "R6");
        step(1'b1, 4'd10, 2'b01, 32'hFFFF_7FFF, 4'd9, 2'b10, 4'd9, 2'b10, 1'b0, 16'h0, "R6");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd9, 2'b10, 4'd10, 2'b10, 1'b0, 16'h0, "R6");
        // R7: address word read sign-extends, address byte read refused
        step(1'b1, 4'd11, 2'b10, 32'h0001_8001, 4'd0, 2'b10, 4'd0, 2'b10, 1'b0, 16'h0, "R7");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd11, 2'b01, 4'd11, 2'b00, 1'b0, 16'h0, "R7");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd10, 2'b01, 4'd11, 2'b10, 1'b0, 16'h0, "R7");
        // R8: all-ones and pattern writes to the condition codes
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd0, 2'b10, 4'd0, 2'b10, 1'b1, 16'hFFFF, "R8");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd0, 2'b10, 4'd0, 2'b10, 1'b1, 16'hAB0A, "R8");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd0, 2'b10, 4'd0, 2'b10, 1'b0, 16'h0, "R8");
        // R9: same-cycle read sees the old value, next cycle the new one
        step(1'b1, 4'd5, 2'b10, 32'hCAFE_F00D, 4'd5, 2'b10, 4'd5, 2'b01, 1'b0, 16'h0, "R9");
        step(1'b0, 4'd5, 2'b10, 32'h1111_1111, 4'd5, 2'b10, 4'd5, 2'b10, 1'b0, 16'h0, "R9");
        // R10: index 0 and index 8 are different registers
        step(1'b1, 4'd8, 2'b10, 32'hDEAD_0000, 4'd0, 2'b10, 4'd8, 2'b10, 1'b0, 16'h0, "R10");
        step(1'b1, 4'd0, 2'b10, 32'h0000_0011, 4'd0, 2'b10, 4'd8, 2'b10, 1'b0, 16'h0, "R10");
        step(1'b0, 4'd0, 2'b10, 32'h0, 4'd0, 2'b10, 4'd8, 2'b10, 1'b0, 16'h0, "R10");

        // Seeded random traffic over all indices and size codes.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] d;
            d = $urandom();
            if (k % 7 == 0) d[15] = ~d[15];
            step(($urandom() % 4) != 0, 4'($urandom()), 2'($urandom()), d,
                 4'($urandom()), 2'($urandom()), 4'($urandom()), 2'($urandom()),
                 ($urandom() % 8) == 0, 16'($urandom()), "R2/R3/R4/R5/R6/R7/R8/R9");
        end

        // R1 again: reset after traffic clears everything.
        do_reset();
        check_all_zero("R1");

        done = 1;
        summary();
        $finish;
    end
endmodule